// File: doc/BRIEF.md
# Loopback Modem Status Generator

This block builds the eight-bit modem status value of a serial port while the port runs in internal loopback. The four modem control outputs are routed inside the block to the four modem status inputs: RTS feeds CTS, DTR feeds DSR, AUX1 feeds RI and AUX2 feeds DCD. On every clock the block compares each incoming control level with the status level it holds. When a line changes, it sets a sticky change flag for that line. The ring line is the exception: its flag is set only on a trailing edge, when RI was 1 and AUX1 is now 0.

A read of the status register pulses a clear strobe. The strobe removes the sticky flags. A change event in the same cycle as a read wins over the clear, so no change is lost. Any flag that is set, together with the modem status interrupt enable, drives the modem status interrupt request. Outside loopback the level nibble is held at zero and no flags are produced.

Top module: `mstat_loop`

## Requirements
- R1: After synchronous active-low reset, `msr_q` is 0x00 and `msi_irq` is 0.
- R2: While `loop_en` is 1, one clock after the control inputs are sampled, `msr_q[7]` equals AUX2, `msr_q[6]` equals AUX1, `msr_q[5]` equals DTR and `msr_q[4]` equals RTS.
- R3: In loopback, a rising or falling change of RTS, DTR or AUX2 against the held level sets `msr_q[0]`, `msr_q[1]` or `msr_q[3]` respectively. The flag is visible one clock after the change is sampled, in the same cycle as the new level.
- R4: In loopback, `msr_q[2]` (ring trailing edge) is set only when the held RI level is 1 and AUX1 is sampled 0. A rising AUX1 does not set it.
- R5: A set change flag stays set while no clear strobe arrives, even after its control line returns to the earlier level.
- R6: A clock with `msr_clr` high and no new change event leaves `msr_q[3:0]` at 0 in the next cycle.
- R7: When `msr_clr` and a change event on a line fall in the same clock, that line's flag is 1 in the next cycle. Flags without an event are cleared.
- R8: While `loop_en` is 0, `msr_q[7:4]` is 0 one clock later and control toggles set no flag. Flags that are already set hold until cleared.
- R9: `msi_irq` is 1 exactly when `msi_en` is 1 and at least one of `msr_q[3:0]` is 1, in the same cycle as `msr_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loop_en | input | 1 | Internal loopback mode active |
| ctl_dtr | input | 1 | DTR control output level |
| ctl_rts | input | 1 | RTS control output level |
| ctl_aux1 | input | 1 | AUX1 control output level |
| ctl_aux2 | input | 1 | AUX2 control output level |
| msr_clr | input | 1 | Clear strobe from a status register read |
| msi_en | input | 1 | Modem status interrupt enable |
| msr_q | output | 8 | Status: [7] DCD, [6] RI, [5] DSR, [4] CTS, [3] DCD change, [2] ring trailing edge, [1] DSR change, [0] CTS change |
| msi_irq | output | 1 | Modem status interrupt request |

## Verification
The controls are driven through rising and falling edges one line at a time and then several lines at once. This shows each flag is tied to its own line and that changes are detected in both directions. AUX1 is driven up and down separately, which separates the trailing-edge rule from the any-change rule. Clear strobes are issued both alone and in the same cycle as an edge, so a clear that wins over an event shows up as a mismatch. Toggles with loopback off and with the interrupt enable off show whether the mode and enable gating leak.

// File: rtl/mstat_pkg.sv
// Package: shared constants and index names for the loopback modem
// status generator. Assumes four modem lines, packed LSB-first as
// CTS, DSR, RI, DCD in both the level and the change nibble.
package mstat_pkg;
    localparam int unsigned LINES   = 4;
    localparam int unsigned MSR_W   = 2 * LINES;
    localparam int unsigned IX_CTS  = 0;
    localparam int unsigned IX_DSR  = 1;
    localparam int unsigned IX_RI   = 2;
    localparam int unsigned IX_DCD  = 3;

    typedef logic [LINES-1:0] line_vec_t;

    typedef struct packed {
        line_vec_t level;
        line_vec_t delta;
    } msr_t;
endpackage

// File: rtl/mstat_line.sv
// Module: one modem status line. Holds the looped-back level and a
// sticky change flag. TRAIL_ONLY selects the ring rule (flag only on
// held 1 -> input 0); otherwise any difference sets the flag.
// Assumes clr is a single-cycle strobe; an event beats a clear.
module mstat_line #(
    parameter bit TRAIL_ONLY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_en,
    input  logic ctl,
    input  logic clr,
    output logic lvl,
    output logic dlt
);
    logic evt;

    // Change detection against the held level, loopback only.
    generate
        if (TRAIL_ONLY) begin : g_trail
            always_comb evt = loop_en & lvl & ~ctl;
        end else begin : g_any
            always_comb evt = loop_en & (lvl ^ ctl);
        end
    endgenerate

    // Level follows the control output in loopback, else held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl <= 1'b0;
        else        lvl <= loop_en & ctl;
    end

    // Sticky change flag: set by an event, cleared by the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)   dlt <= 1'b0;
        else if (evt) dlt <= 1'b1;
        else if (clr) dlt <= 1'b0;
    end

    p_level_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |=> (lvl == $past(ctl)));
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dlt && !clr) |=> dlt);
    p_quiet_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |=> !lvl);
    p_quiet_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_en && !dlt) |=> !dlt);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !loop_en) |=> !dlt);

    generate
        if (TRAIL_ONLY) begin : g_trail_chk
            p_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (!lvl && !dlt) |=> !dlt);
        end else begin : g_any_chk
            p_both_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (loop_en && (lvl != ctl)) |=> dlt);
        end
    endgenerate
endmodule

// File: rtl/mstat_irq.sv
// Module: modem status interrupt request. Any sticky change flag,
// gated by the enable, raises the request without a register stage.
module mstat_irq #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] delta,
    input  logic         en,
    output logic         irq
);
    // Combine flags and enable.
    always_comb irq = en & (|delta);

    p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !irq);
    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (delta != '0));
endmodule

// File: rtl/mstat_loop.sv
// Module: loopback modem status generator top. Routes RTS->CTS,
// DTR->DSR, AUX1->RI, AUX2->DCD through one mstat_line per line and
// packs the result as {levels, changes}. Assumes msr_clr pulses once
// per status read.
module mstat_loop
    import mstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loop_en,
    input  logic             ctl_dtr,
    input  logic             ctl_rts,
    input  logic             ctl_aux1,
    input  logic             ctl_aux2,
    input  logic             msr_clr,
    input  logic             msi_en,
    output logic [MSR_W-1:0] msr_q,
    output logic             msi_irq
);
    line_vec_t ctl_v;
    line_vec_t lvl_v;
    line_vec_t dlt_v;
    msr_t      msr_s;

    // Map control outputs onto status line positions.
    always_comb begin
        ctl_v         = '0;
        ctl_v[IX_CTS] = ctl_rts;
        ctl_v[IX_DSR] = ctl_dtr;
        ctl_v[IX_RI]  = ctl_aux1;
        ctl_v[IX_DCD] = ctl_aux2;
    end

    genvar gi;
    generate
        for (gi = 0; gi < LINES; gi++) begin : g_line
            mstat_line #(
                .TRAIL_ONLY(gi == IX_RI)
            ) i_line (
                .clk     (clk),
                .rst_n   (rst_n),
                .loop_en (loop_en),
                .ctl     (ctl_v[gi]),
                .clr     (msr_clr),
                .lvl     (lvl_v[gi]),
                .dlt     (dlt_v[gi])
            );
        end
    endgenerate

    // Pack levels and change flags into the status byte.
    always_comb begin
        msr_s.level = lvl_v;
        msr_s.delta = dlt_v;
        msr_q       = msr_s;
    end

    mstat_irq #(
        .N(LINES)
    ) i_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .delta (dlt_v),
        .en    (msi_en),
        .irq   (msi_irq)
    );

    p_event_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_clr && loop_en && ctl_rts != msr_q[4]) |=> msr_q[0]);
endmodule

// File: tb/test_mstat_loop.sv
module test_mstat_loop;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loop_en = 1'b0, ctl_dtr = 1'b0, ctl_rts = 1'b0;
    logic       ctl_aux1 = 1'b0, ctl_aux2 = 1'b0, msr_clr = 1'b0, msi_en = 1'b0;
    logic [7:0] msr_q;
    logic       msi_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] msr;
        logic       irq;
        string      tag;
    } exp_t;
    exp_t sb[$];

    // Reference state from the requirements: level {DCD,RI,DSR,CTS}, flags likewise.
    logic [3:0] m_lvl = '0;
    logic [3:0] m_dlt = '0;

    mstat_loop i_mstat_loop (
        .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .ctl_dtr(ctl_dtr),
        .ctl_rts(ctl_rts), .ctl_aux1(ctl_aux1), .ctl_aux2(ctl_aux2),
        .msr_clr(msr_clr), .msi_en(msi_en), .msr_q(msr_q), .msi_irq(msi_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: apply one cycle of inputs at negedge and push the expected result.
    task automatic step(input bit lp, input bit a2, input bit a1, input bit dtr,
                        input bit rts, input bit rd, input bit en, input string tag);
        logic [3:0] c;
        logic [3:0] ev;
        exp_t e;
        @(negedge clk);
        loop_en = lp; ctl_aux2 = a2; ctl_aux1 = a1; ctl_dtr = dtr;
        ctl_rts = rts; msr_clr = rd; msi_en = en;
        c = {a2, a1, dtr, rts};
        for (int i = 0; i < 4; i++) begin
            if (!lp)         ev[i] = 1'b0;
            else if (i == 2) ev[i] = m_lvl[i] & ~c[i];
            else             ev[i] = m_lvl[i] ^ c[i];
        end
        m_dlt = ev | (rd ? 4'b0 : m_dlt);
        m_lvl = lp ? c : 4'b0;
        e.msr = {m_lvl, m_dlt};
        e.irq = en & (|m_dlt);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: after each edge, pop and compare one expected item.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (msr_q !== e.msr || msi_irq !== e.irq) begin
                n_fail++;
                $display("FAIL %s: msr=%02h irq=%b expected msr=%02h irq=%b",
                         e.tag, msr_q, msi_irq, e.msr, e.irq);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if (msr_q !== 8'h00 || msi_irq !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: msr=%02h irq=%b expected msr=00 irq=0", msr_q, msi_irq);
        end
        @(negedge clk);
        rst_n = 1'b1;
        //   lp a2 a1 dtr rts rd en
        step(1, 0, 0, 0, 0, 0, 0, "R2 idle loopback");
        step(1, 0, 0, 0, 1, 0, 0, "R3 RTS rise");
        step(1, 0, 0, 0, 0, 0, 0, "R5 RTS back, flag sticky");
        step(1, 0, 0, 0, 0, 1, 0, "R6 clear");
        step(1, 0, 0, 1, 0, 0, 1, "R3 DTR rise / R9 irq");
        step(1, 1, 0, 1, 0, 1, 1, "R7 AUX2 rise with clear");
        step(1, 1, 0, 1, 0, 1, 1, "R6 clear / R9 irq drop");
        step(1, 1, 1, 1, 0, 0, 1, "R4 AUX1 rise no flag");
        step(1, 1, 1, 1, 0, 0, 1, "R2 levels held");
        step(1, 1, 0, 1, 0, 1, 1, "R4 R7 AUX1 fall with clear");
        step(1, 0, 0, 0, 0, 0, 0, "R3 DCD DSR fall, R9 enable off");
        step(1, 1, 1, 1, 1, 1, 1, "R3 all rise with clear");
        step(1, 0, 0, 0, 0, 1, 1, "R3 R4 all fall with clear");
        step(1, 0, 0, 0, 0, 1, 1, "R6 clear");
        step(1, 1, 0, 0, 1, 0, 0, "R2 mixed levels");
        step(0, 1, 1, 1, 1, 0, 1, "R8 leave loopback, flags held");
        step(0, 0, 1, 0, 1, 0, 1, "R8 toggles ignored");
        step(0, 1, 0, 1, 0, 1, 1, "R8 clear outside loopback");
        step(0, 0, 1, 1, 0, 0, 1, "R8 quiet");
        step(1, 0, 1, 1, 0, 0, 1, "R3 re-enter loopback");
        step(1, 0, 0, 1, 0, 0, 1, "R4 RI fall");
        step(1, 0, 0, 1, 0, 0, 0, "R9 enable off");
        step(1, 0, 0, 1, 0, 0, 0, "R5 hold");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule